// File: doc/BRIEF.md
# Multidrop Serial Control-Bus Slave

This block is the far end of a serial configuration link shared by one master and up to 32 slaves. The master sends frames of 10-bit words on a downstream clock/data pair. That link clock toggles only while bits are moving and stays low between frames. The slave oversamples the pair with its own system clock, assembles words, and compares the address in each frame header with its strapped identity. Frames for other slaves are skipped by their word count. Frames for this slave become write or read cycles on a local parallel register bus that has 16-bit data and 8-bit addresses.

Read data goes back on a separate upstream clock/data pair that the slave drives itself. The link has no acknowledge slots in either direction. When a frame is malformed, or the downstream clock stalls in the middle of a frame, the slave raises an interrupt level and the master repeats the transfer. A repeated frame simply executes again. The control state machine is one-hot, and its state register is held in three copies that are majority-voted every cycle.

Top module: `scbus_slave`

## Requirements
- R1: During and right after reset, busWr, busRd, upClk, upData and irq are all low.
- R2: A downstream bit is taken on each rising edge of dnClk, after a two-stage synchroniser. Ten bits make one word, most significant bit first.
- R3: A frame starts with two header words. Word 0 holds the target address in [9:5], the read flag in [4] (1 = read) and reserved bits [3:0], which must be zero. Word 1 holds, in [7:0], the number of words that follow; its bits [9:8] are ignored.
- R4: A frame whose address differs from slaveId is skipped for exactly its stated word count. It causes no bus access and no change of irq, even when its body words look like headers.
- R5: A write body is one address word ([7:0]) followed by pairs of a high-byte word and a low-byte word (data in [7:0]). Each complete pair issues one single-cycle busWr of {high, low}, and the address increments after each access. A trailing unpaired high word is discarded.
- R6: A read frame must have a count of exactly 2: an address word, then a register-number word N in [7:0]. For each of the N registers the slave issues one single-cycle busRd, takes busRdData one cycle later, and returns two upstream words, {2'b00, high byte} then {2'b00, low byte}, with the address incrementing. When N is 0 nothing is read.
- R7: upClk idles low. Each upstream bit is presented while upClk is low, and upClk then goes high for UP_HALF system cycles after a low phase of UP_HALF cycles, most significant bit first. upData does not change while upClk is high.
- R8: Write frames produce no upstream clock activity; there is no acknowledge slot.
- R9: A frame for this slave with nonzero reserved header bits, or a read frame whose count is not 2, is skipped by its count without any bus access, and irq goes high.
- R10: If no dnClk rising edge arrives for IDLE_LIMIT system cycles while a frame or a partial word is in progress, the frame is abandoned, the partial word is dropped and irq goes high. The next frame is then decoded correctly.
- R11: irq goes low once a well-formed frame for this slave completes. Sending the same frame again repeats the same bus accesses with the same end result.
- R12: If any one of the three copies of the control state is corrupted, operation is unaffected. Frames in progress complete with the correct bus accesses and upstream data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveId | input | 5 | Strapped slave address |
| dnClk | input | 1 | Downstream link clock, gated |
| dnData | input | 1 | Downstream link data |
| upClk | output | 1 | Upstream link clock, gated, driven by the slave |
| upData | output | 1 | Upstream link data |
| irq | output | 1 | Interrupt level toward the master |
| busAddr | output | 8 | Local register bus address |
| busWrData | output | 16 | Local bus write data |
| busWr | output | 1 | Local bus write strobe |
| busRd | output | 1 | Local bus read strobe |
| busRdData | input | 16 | Local bus read data, valid one cycle after busRd |

## Verification
The hardest situation to reach from the ports is a corrupted copy of the voted state register in the middle of a live transfer. No legal link traffic can cause it. The bench forces one copy to all zeros for a few cycles, once while a write frame is arriving and once while upstream read data is being shifted out. It then checks that every bus write and every returned word is still exact. Stalls are produced by stopping the downstream clock after the header of a frame and after only four bits of a word, and the bench confirms that the following frame decodes cleanly.

// File: rtl/scbus_pkg.sv
package scbus_pkg;
  localparam int WORD_W = 10;
  localparam int ID_W   = 5;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - BYTE_W;

  typedef enum int {
    S_IDLE = 0, S_COUNT, S_ADDR, S_RDNUM, S_WRHI, S_WRLO, S_SKIP,
    S_RDREQ, S_RDWAIT, S_RDLAT, S_TX
  } stateIdx_e;
  localparam int NUM_ST = 11;

  typedef struct packed {
    logic latchHdr;
    logic loadCnt;
    logic consume;
    logic loadAddr;
    logic latchHi;
    logic doWrite;
    logic loadRegs;
    logic doRead;
    logic txLoad;
    logic setIrq;
    logic clrIrq;
    logic inFrame;
  } ctrlStrobe_t;

  typedef struct packed {
    logic wordValid;
    logic lastWord;
    logic cntZero;
    logic cntTwo;
    logic hdrMine;
    logic hdrRead;
    logic hdrBad;
    logic regsDone;
    logic txDone;
    logic timeout;
  } dpStatus_t;
endpackage

// File: rtl/scbus_datapath.sv
module scbus_datapath
  import scbus_pkg::*;
#(
  parameter int IDLE_LIMIT = 64,
  parameter int UP_HALF    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ID_W-1:0]     slaveId,
  input  logic                dnClk,
  input  logic                dnData,
  input  ctrlStrobe_t         strobe,
  output dpStatus_t           status,
  output logic                upClk,
  output logic                upData,
  output logic                irq,
  output logic [BYTE_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busWrData,
  output logic                busWr,
  output logic                busRd,
  input  logic [DATA_W-1:0]   busRdData
);
  localparam int IDLE_W  = $clog2(IDLE_LIMIT + 2);
  localparam int BIT_W   = $clog2(WORD_W + 1);
  localparam int HALF_W  = $clog2(UP_HALF + 1);
  localparam int TX_BITS = 2 * WORD_W;
  localparam int TXC_W   = $clog2(TX_BITS + 1);

  // link synchronisers
  logic [2:0] clkSync;
  logic [1:0] dataSync;
  logic       linkRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
    end else begin
      clkSync  <= {clkSync[1:0], dnClk};
      dataSync <= {dataSync[0], dnData};
    end
  end
  assign linkRise = clkSync[1] & ~clkSync[2];

  // word receiver and stall detector
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] rxWord;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              wordValid;
  logic              timeoutHit;

  assign timeoutHit = (idleCnt == IDLE_W'(IDLE_LIMIT)) && ((bitCnt != '0) || strobe.inFrame);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rxWord    <= '0;
      bitCnt    <= '0;
      idleCnt   <= IDLE_W'(IDLE_LIMIT + 1);
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (linkRise) begin
        shiftReg <= {shiftReg[WORD_W-2:0], dataSync[1]};
        idleCnt  <= '0;
        if (bitCnt == BIT_W'(WORD_W - 1)) begin
          bitCnt    <= '0;
          wordValid <= 1'b1;
          rxWord    <= {shiftReg[WORD_W-2:0], dataSync[1]};
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        if (idleCnt != IDLE_W'(IDLE_LIMIT + 1)) idleCnt <= idleCnt + 1'b1;
        if (timeoutHit) bitCnt <= '0;
      end
    end
  end

  // header and frame bookkeeping
  logic              hdrMine, hdrRead, hdrBad;
  logic [BYTE_W-1:0] remCnt;
  logic [BYTE_W-1:0] regsLeft;
  logic [BYTE_W-1:0] addrReg;
  logic [BYTE_W-1:0] hiByte;
  logic [DATA_W-1:0] wrDataReg;
  logic              busWrReg, busRdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrMine   <= 1'b0;
      hdrRead   <= 1'b0;
      hdrBad    <= 1'b0;
      remCnt    <= '0;
      regsLeft  <= '0;
      addrReg   <= '0;
      hiByte    <= '0;
      wrDataReg <= '0;
      busWrReg  <= 1'b0;
      busRdReg  <= 1'b0;
    end else begin
      if (strobe.latchHdr) begin
        hdrMine <= (rxWord[WORD_W-1 -: ID_W] == slaveId);
        hdrRead <= rxWord[WORD_W-ID_W-1];
        hdrBad  <= |rxWord[WORD_W-ID_W-2:0];
      end
      if (strobe.loadCnt)      remCnt <= rxWord[BYTE_W-1:0];
      else if (strobe.consume) remCnt <= remCnt - 1'b1;

      if (strobe.loadRegs)    regsLeft <= rxWord[BYTE_W-1:0];
      else if (strobe.txLoad) regsLeft <= regsLeft - 1'b1;

      if (strobe.loadAddr)          addrReg <= rxWord[BYTE_W-1:0];
      else if (busWrReg || busRdReg) addrReg <= addrReg + 1'b1;

      if (strobe.latchHi) hiByte <= rxWord[BYTE_W-1:0];
      if (strobe.doWrite) wrDataReg <= {hiByte, rxWord[BYTE_W-1:0]};
      busWrReg <= strobe.doWrite;
      busRdReg <= strobe.doRead;
    end
  end

  // upstream shifter with its own gated clock
  logic [TX_BITS-1:0] txShift;
  logic [TXC_W-1:0]   txLeft;
  logic [HALF_W-1:0]  halfCnt;
  logic               upClkReg, txBusy, txDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      txLeft   <= '0;
      halfCnt  <= '0;
      upClkReg <= 1'b0;
      txBusy   <= 1'b0;
      txDone   <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (strobe.txLoad) begin
        txShift  <= {{PAD_W{1'b0}}, busRdData[DATA_W-1 -: BYTE_W],
                     {PAD_W{1'b0}}, busRdData[BYTE_W-1:0]};
        txLeft   <= TXC_W'(TX_BITS);
        halfCnt  <= '0;
        upClkReg <= 1'b0;
        txBusy   <= 1'b1;
      end else if (txBusy) begin
        if (halfCnt == HALF_W'(UP_HALF - 1)) begin
          halfCnt  <= '0;
          upClkReg <= ~upClkReg;
          if (upClkReg) begin
            txShift <= {txShift[TX_BITS-2:0], 1'b0};
            txLeft  <= txLeft - 1'b1;
            if (txLeft == TXC_W'(1)) begin
              txBusy <= 1'b0;
              txDone <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  // interrupt level, set wins over clear
  logic irqReg;
  always_ff @(posedge clk) begin
    if (!rstN)              irqReg <= 1'b0;
    else if (strobe.setIrq) irqReg <= 1'b1;
    else if (strobe.clrIrq) irqReg <= 1'b0;
  end

  assign status.wordValid = wordValid;
  assign status.lastWord  = (remCnt == BYTE_W'(1));
  assign status.cntZero   = (rxWord[BYTE_W-1:0] == '0);
  assign status.cntTwo    = (rxWord[BYTE_W-1:0] == BYTE_W'(2));
  assign status.hdrMine   = hdrMine;
  assign status.hdrRead   = hdrRead;
  assign status.hdrBad    = hdrBad;
  assign status.regsDone  = (regsLeft == '0);
  assign status.txDone    = txDone;
  assign status.timeout   = timeoutHit;

  assign upClk     = upClkReg;
  assign upData    = txBusy & txShift[TX_BITS-1];
  assign irq       = irqReg;
  assign busAddr   = addrReg;
  assign busWrData = wrDataReg;
  assign busWr     = busWrReg;
  assign busRd     = busRdReg;
endmodule

// File: rtl/scbus_ctrl.sv
module scbus_ctrl
  import scbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);
  localparam logic [NUM_ST-1:0] IDLE_VEC = NUM_ST'(1) << S_IDLE;

  // three copies of the one-hot state, majority-voted
  logic [NUM_ST-1:0] stA, stB, stC;
  logic [NUM_ST-1:0] voted, nxt;

  assign voted = (stA & stB) | (stB & stC) | (stA & stC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stA <= IDLE_VEC;
      stB <= IDLE_VEC;
      stC <= IDLE_VEC;
    end else begin
      stA <= nxt;
      stB <= nxt;
      stC <= nxt;
    end
  end

  always_comb begin
    nxt    = '0;
    strobe = '0;
    strobe.inFrame = voted[S_COUNT] | voted[S_ADDR] | voted[S_RDNUM] |
                     voted[S_WRHI]  | voted[S_WRLO] | voted[S_SKIP];

    if (status.timeout && (voted[S_IDLE] || strobe.inFrame)) begin
      strobe.setIrq = 1'b1;
      nxt[S_IDLE]   = 1'b1;
    end else if (voted[S_IDLE]) begin
      if (status.wordValid) begin
        strobe.latchHdr = 1'b1;
        nxt[S_COUNT]    = 1'b1;
      end else begin
        nxt[S_IDLE] = 1'b1;
      end
    end else if (voted[S_COUNT]) begin
      if (!status.wordValid) begin
        nxt[S_COUNT] = 1'b1;
      end else begin
        strobe.loadCnt = 1'b1;
        if (!status.hdrMine) begin
          if (status.cntZero) nxt[S_IDLE] = 1'b1;
          else                nxt[S_SKIP] = 1'b1;
        end else if (status.hdrBad || (status.hdrRead && !status.cntTwo)) begin
          strobe.setIrq = 1'b1;
          if (status.cntZero) nxt[S_IDLE] = 1'b1;
          else                nxt[S_SKIP] = 1'b1;
        end else if (status.cntZero) begin
          strobe.clrIrq = 1'b1;
          nxt[S_IDLE]   = 1'b1;
        end else begin
          nxt[S_ADDR] = 1'b1;
        end
      end
    end else if (voted[S_ADDR]) begin
      if (!status.wordValid) begin
        nxt[S_ADDR] = 1'b1;
      end else begin
        strobe.consume  = 1'b1;
        strobe.loadAddr = 1'b1;
        if (status.lastWord) begin
          strobe.clrIrq = 1'b1;
          nxt[S_IDLE]   = 1'b1;
        end else if (status.hdrRead) begin
          nxt[S_RDNUM] = 1'b1;
        end else begin
          nxt[S_WRHI] = 1'b1;
        end
      end
    end else if (voted[S_RDNUM]) begin
      if (!status.wordValid) begin
        nxt[S_RDNUM] = 1'b1;
      end else begin
        strobe.consume  = 1'b1;
        strobe.loadRegs = 1'b1;
        if (status.cntZero) begin
          strobe.clrIrq = 1'b1;
          nxt[S_IDLE]   = 1'b1;
        end else begin
          nxt[S_RDREQ] = 1'b1;
        end
      end
    end else if (voted[S_WRHI]) begin
      if (!status.wordValid) begin
        nxt[S_WRHI] = 1'b1;
      end else begin
        strobe.consume = 1'b1;
        strobe.latchHi = 1'b1;
        if (status.lastWord) begin
          strobe.clrIrq = 1'b1;
          nxt[S_IDLE]   = 1'b1;
        end else begin
          nxt[S_WRLO] = 1'b1;
        end
      end
    end else if (voted[S_WRLO]) begin
      if (!status.wordValid) begin
        nxt[S_WRLO] = 1'b1;
      end else begin
        strobe.consume = 1'b1;
        strobe.doWrite = 1'b1;
        if (status.lastWord) begin
          strobe.clrIrq = 1'b1;
          nxt[S_IDLE]   = 1'b1;
        end else begin
          nxt[S_WRHI] = 1'b1;
        end
      end
    end else if (voted[S_SKIP]) begin
      if (!status.wordValid) begin
        nxt[S_SKIP] = 1'b1;
      end else begin
        strobe.consume = 1'b1;
        if (status.lastWord) nxt[S_IDLE] = 1'b1;
        else                 nxt[S_SKIP] = 1'b1;
      end
    end else if (voted[S_RDREQ]) begin
      strobe.doRead = 1'b1;
      nxt[S_RDWAIT] = 1'b1;
    end else if (voted[S_RDWAIT]) begin
      nxt[S_RDLAT] = 1'b1;
    end else if (voted[S_RDLAT]) begin
      strobe.txLoad = 1'b1;
      nxt[S_TX]     = 1'b1;
    end else if (voted[S_TX]) begin
      if (!status.txDone) begin
        nxt[S_TX] = 1'b1;
      end else if (status.regsDone) begin
        strobe.clrIrq = 1'b1;
        nxt[S_IDLE]   = 1'b1;
      end else begin
        nxt[S_RDREQ] = 1'b1;
      end
    end else begin
      nxt[S_IDLE] = 1'b1;
    end
  end
endmodule

// File: rtl/scbus_slave.sv
module scbus_slave
  import scbus_pkg::*;
#(
  parameter int IDLE_LIMIT = 64,
  parameter int UP_HALF    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   slaveId,
  input  logic              dnClk,
  input  logic              dnData,
  output logic              upClk,
  output logic              upData,
  output logic              irq,
  output logic [BYTE_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic              busWr,
  output logic              busRd,
  input  logic [DATA_W-1:0] busRdData
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  scbus_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  scbus_datapath #(
    .IDLE_LIMIT (IDLE_LIMIT),
    .UP_HALF    (UP_HALF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .slaveId   (slaveId),
    .dnClk     (dnClk),
    .dnData    (dnData),
    .strobe    (strobe),
    .status    (status),
    .upClk     (upClk),
    .upData    (upData),
    .irq       (irq),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .busRdData (busRdData)
  );
endmodule

// File: rtl/scbus_checker.sv
module scbus_checker (
  input logic clk,
  input logic rstN,
  input logic busWr,
  input logic busRd,
  input logic upClk,
  input logic upData,
  input logic irq,
  input logic setIrq,
  input logic clrIrq
);
  assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  assert_wr_single_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> !busWr);

  assert_rd_single_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> !busRd);

  assert_up_data_steady_R7: assert property (@(posedge clk) disable iff (!rstN)
    (upClk && $past(upClk)) |-> $stable(upData));

  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(setIrq));

  assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(clrIrq));
endmodule

bind scbus_slave scbus_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busWr  (busWr),
  .busRd  (busRd),
  .upClk  (upClk),
  .upData (upData),
  .irq    (irq),
  .setIrq (strobe.setIrq),
  .clrIrq (strobe.clrIrq)
);

// File: tb/scbus_slave_tb.sv
module scbus_slave_tb;
  localparam int IDLE_LIMIT = 64;
  localparam int UP_HALF    = 12;
  localparam int DN_HALF    = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  slaveId = 5'd9;
  logic        dnClk = 1'b0;
  logic        dnData = 1'b0;
  logic        upClk, upData, irq, busWr, busRd;
  logic [7:0]  busAddr;
  logic [15:0] busWrData;
  logic [15:0] busRdData = '0;

  always #2 clk = ~clk;

  scbus_slave #(.IDLE_LIMIT(IDLE_LIMIT), .UP_HALF(UP_HALF)) u_dut (
    .clk(clk), .rstN(rstN), .slaveId(slaveId), .dnClk(dnClk), .dnData(dnData),
    .upClk(upClk), .upData(upData), .irq(irq), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd), .busRdData(busRdData)
  );

  // local register bus: synchronous memory
  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (busWr) mem[busAddr] <= busWrData;
    if (busRd) busRdData <= mem[busAddr];
  end

  // behavioural reference model
  logic [15:0] refMem [256];
  logic [23:0] expWr [$];
  logic [9:0]  expUp [$];
  logic [9:0]  frm [$];
  logic [15:0] dat [$];
  int checks = 0;
  int fails  = 0;
  int upRises = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // bus-write monitor, compared on every clock
  always @(negedge clk) begin
    if (rstN && busWr) begin
      if (expWr.size() == 0) begin
        check(1'b0, "R4/R9", "unexpected busWr addr", int'(busAddr), -1);
      end else begin
        logic [23:0] e;
        e = expWr.pop_front();
        check({busAddr, busWrData} == e, "R5", "busWr {addr,data}",
              int'({busAddr, busWrData}), int'(e));
      end
    end
  end

  // upstream receiver model: sample on upClk rise
  logic       prevUp = 1'b0;
  logic [9:0] upWord = '0;
  int         upBits = 0;
  always @(negedge clk) begin
    if (rstN && upClk && !prevUp) begin
      upRises++;
      upWord = {upWord[8:0], upData};
      upBits++;
      if (upBits == 10) begin
        upBits = 0;
        if (expUp.size() == 0) begin
          check(1'b0, "R8/R9", "unexpected upstream word", int'(upWord), -1);
        end else begin
          logic [9:0] e;
          e = expUp.pop_front();
          check(upWord == e, "R6/R7", "upstream word", int'(upWord), int'(e));
        end
      end
    end
    prevUp = upClk;
  end

  task automatic sendBits(input logic [9:0] w, input int n);
    for (int i = 9; i > 9 - n; i--) begin
      @(negedge clk);
      dnData = w[i];
      repeat (DN_HALF) @(negedge clk);
      dnClk = 1'b1;
      repeat (DN_HALF) @(negedge clk);
      dnClk = 1'b0;
    end
  endtask

  task automatic sendFrm();
    foreach (frm[i]) sendBits(frm[i], 10);
    repeat (30) @(negedge clk);
  endtask

  task automatic buildWrite(input logic [4:0] id, input logic [7:0] addr);
    frm.delete();
    frm.push_back({id, 1'b0, 4'b0000});
    frm.push_back(10'(1 + 2 * dat.size()));
    frm.push_back({2'b00, addr});
    foreach (dat[i]) begin
      frm.push_back({2'b00, dat[i][15:8]});
      frm.push_back({2'b00, dat[i][7:0]});
      if (id == slaveId) begin
        expWr.push_back({8'(addr + i), dat[i]});
        refMem[8'(addr + i)] = dat[i];
      end
    end
  endtask

  task automatic readFrame(input logic [7:0] addr, input int n);
    frm.delete();
    frm.push_back({slaveId, 1'b1, 4'b0000});
    frm.push_back(10'd2);
    frm.push_back({2'b00, addr});
    frm.push_back(10'(n));
    for (int i = 0; i < n; i++) begin
      expUp.push_back({2'b00, refMem[8'(addr + i)][15:8]});
      expUp.push_back({2'b00, refMem[8'(addr + i)][7:0]});
    end
    sendFrm();
    repeat (n * 40 * UP_HALF + 40) @(negedge clk);
  endtask

  task automatic checkDone(input string tag);
    check(expWr.size() == 0, tag, "pending writes", expWr.size(), 0);
    check(expUp.size() == 0, tag, "pending upstream words", expUp.size(), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int upBefore;
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      refMem[i] = '0;
    end
    repeat (8) @(negedge clk);
    // R1 reset state
    check(busWr == 0, "R1", "busWr in reset", busWr, 0);
    check(busRd == 0, "R1", "busRd in reset", busRd, 0);
    check(upClk == 0, "R1", "upClk in reset", upClk, 0);
    check(upData == 0, "R1", "upData in reset", upData, 0);
    check(irq == 0, "R1", "irq in reset", irq, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(irq == 0 && busWr == 0 && upClk == 0, "R1", "idle after reset", irq, 0);

    // R2 R3 R5 R8: plain write of three registers
    dat = '{16'hA55A, 16'h1234, 16'hFFFF};
    buildWrite(slaveId, 8'h10);
    upBefore = upRises;
    sendFrm();
    checkDone("R5");
    check(upRises == upBefore, "R8", "upClk edges during write", upRises - upBefore, 0);
    check(irq == 0, "R3", "irq after good write", irq, 0);

    // R6 R7: read back three registers
    readFrame(8'h10, 3);
    checkDone("R6");

    // R4: foreign frame with header-like body words
    frm.delete();
    frm.push_back({5'd3, 1'b0, 4'b0000});
    frm.push_back(10'd3);
    frm.push_back(10'h010);
    frm.push_back({slaveId, 1'b1, 4'b0000});
    frm.push_back(10'd2);
    sendFrm();
    checkDone("R4");
    check(irq == 0, "R4", "irq after foreign frame", irq, 0);
    readFrame(8'h10, 1);
    checkDone("R4");

    // R5: trailing unpaired high word dropped
    frm.delete();
    frm.push_back({slaveId, 1'b0, 4'b0000});
    frm.push_back(10'd4);
    frm.push_back(10'h020);
    frm.push_back(10'h012);
    frm.push_back(10'h034);
    frm.push_back(10'h056);
    expWr.push_back({8'h20, 16'h1234});
    refMem[8'h20] = 16'h1234;
    sendFrm();
    checkDone("R5");
    readFrame(8'h20, 2);
    checkDone("R5");

    // R9: reserved header bits set
    frm.delete();
    frm.push_back({slaveId, 1'b0, 4'b0100});
    frm.push_back(10'd3);
    frm.push_back(10'h030);
    frm.push_back(10'h011);
    frm.push_back(10'h022);
    sendFrm();
    checkDone("R9");
    check(irq == 1, "R9", "irq after reserved bits", irq, 1);

    // R11: good frame clears irq
    dat = '{16'h0BAD};
    buildWrite(slaveId, 8'h30);
    sendFrm();
    checkDone("R11");
    check(irq == 0, "R11", "irq cleared by good frame", irq, 0);

    // R9: read frame with count 3
    frm.delete();
    frm.push_back({slaveId, 1'b1, 4'b0000});
    frm.push_back(10'd3);
    frm.push_back(10'h010);
    frm.push_back(10'h001);
    frm.push_back(10'h000);
    sendFrm();
    repeat (600) @(negedge clk);
    checkDone("R9");
    check(irq == 1, "R9", "irq after bad read count", irq, 1);

    // R6 R11: read of zero registers completes and clears irq
    readFrame(8'h10, 0);
    checkDone("R6");
    check(irq == 0, "R11", "irq after zero-length read", irq, 0);

    // R10: stall after header and address
    frm.delete();
    frm.push_back({slaveId, 1'b0, 4'b0000});
    frm.push_back(10'd5);
    frm.push_back(10'h040);
    sendFrm();
    repeat (IDLE_LIMIT + 40) @(negedge clk);
    checkDone("R10");
    check(irq == 1, "R10", "irq after mid-frame stall", irq, 1);
    dat = '{16'h7777};
    buildWrite(slaveId, 8'h40);
    sendFrm();
    checkDone("R10");
    check(irq == 0, "R10", "irq after recovery frame", irq, 0);

    // R10: stall inside a word
    sendBits({slaveId, 1'b0, 4'b0000}, 4);
    repeat (IDLE_LIMIT + 40) @(negedge clk);
    check(irq == 1, "R10", "irq after partial word", irq, 1);
    dat = '{16'h8888};
    buildWrite(slaveId, 8'h41);
    sendFrm();
    checkDone("R10");
    check(irq == 0, "R10", "irq after resync frame", irq, 0);

    // R11: identical frame twice
    dat = '{16'h1111, 16'h2222};
    buildWrite(slaveId, 8'h50);
    sendFrm();
    checkDone("R11");
    dat = '{16'h1111, 16'h2222};
    buildWrite(slaveId, 8'h50);
    sendFrm();
    checkDone("R11");
    readFrame(8'h50, 2);
    checkDone("R11");

    // R12: one state copy corrupted during a write frame
    dat = '{16'hCAFE, 16'hBEEF, 16'h0102};
    buildWrite(slaveId, 8'h60);
    fork
      sendFrm();
      begin
        repeat (700) @(negedge clk);
        force u_dut.u_ctrl.stB = '0;
        repeat (3) @(negedge clk);
        release u_dut.u_ctrl.stB;
      end
    join
    checkDone("R12");
    check(irq == 0, "R12", "irq after upset in write", irq, 0);

    // R12: one state copy corrupted during upstream shifting
    fork
      readFrame(8'h60, 3);
      begin
        repeat (1400) @(negedge clk);
        force u_dut.u_ctrl.stC = '0;
        repeat (3) @(negedge clk);
        release u_dut.u_ctrl.stC;
      end
    join
    checkDone("R12");
    check(irq == 0, "R12", "irq after upset in read", irq, 0);

    summary();
    $finish;
  end
endmodule